// File: doc/BRIEF.md
# Circuit-Switched Mesh Router with Probe Rerouting

This block is one node of a circuit-switched 2-D mesh network. It has five ports: north, east, south and west lead to neighbouring nodes, and a fifth port leads to the local processing element. A connection is built by a setup probe that travels hop by hop and carries the destination coordinates. At each node an input controller picks a productive output for the probe. X is resolved first, then Y. If the preferred output is already reserved, the controller takes the other productive output rather than waiting. If no productive output is free, the probe is refused with a negative acknowledge on the backward channel of the port it came in on. The upstream node can then try a different output.

Each output keeps an owner register naming the input that reserved it. That register also sets the output's multiplexer, so the crossbar carries both the setup probe and the data bytes that follow. A node that holds the destination delivers the probe to its local port and sends a positive acknowledge back. Acknowledges from downstream are relayed back along the reserved path. Once connected, the input forwards 8-bit data through one register stage per hop until a teardown flit passes and releases each output on its way.

Top module: `noc_cs_router`

## Requirements
- R1: While reset is high, and on the first cycle after it, every output valid and every backward acknowledge and refusal signal is low, and no output is reserved.
- R2: A flit has a 2-bit kind (0 data, 1 probe, 2 teardown, 3 ignored) and an 8-bit byte. A probe byte holds the destination X in bits 5:3 and Y in bits 2:0. Ports are indexed 0 north, 1 east, 2 south, 3 west and 4 local. East raises X and north raises Y. An idle input that receives a probe sends it, byte unchanged, on the X-direction output if X differs, otherwise on the Y-direction output. The probe appears on that output two clock edges after it is presented.
- R3: If the preferred output is reserved and the other productive direction is free, the probe leaves on that other output.
- R4: If no productive output is free, the input raises a one-cycle refusal on its own port's backward channel two edges after the probe and returns to idle. A refusal never coincides with an acknowledge on the same port.
- R5: A refusal arriving from downstream on a reserved output releases that output. The input then retries on a productive output it has not yet tried during this setup. When none is left, it refuses upstream.
- R6: A probe whose destination equals the node's own coordinates goes to the local port. In the same cycle the node raises an acknowledge on the input's backward channel.
- R7: An acknowledge arriving from downstream on a reserved output appears one edge later on the backward channel of the owning input, and that input becomes connected.
- R8: A connected input forwards each data flit to its reserved output after one clock edge. Data or ignored-kind flits on an input that is idle, seeking or waiting for an acknowledge produce no output.
- R9: A teardown flit on a connected input is forwarded like data and releases the reserved output, so that output is free for a later probe.
- R10: Probes from different inputs that want the same free output in the same cycle are resolved round-robin per output. The pointer moves to the input just past the winner. The loser retries next cycle under R3 and R4.
- R11: An output that is reserved is never granted again until it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 5 | Flit valid per input port |
| in_kind | input | 10 | Flit kind per input port, 2 bits each |
| in_pay | input | 40 | Flit byte per input port, 8 bits each |
| out_vld | output | 5 | Flit valid per output port |
| out_kind | output | 10 | Flit kind per output port |
| out_pay | output | 40 | Flit byte per output port |
| bk_in_ack | input | 5 | Acknowledge received from downstream, per output port |
| bk_in_nack | input | 5 | Refusal received from downstream, per output port |
| bk_out_ack | output | 5 | Acknowledge sent upstream, per input port |
| bk_out_nack | output | 5 | Refusal sent upstream, per input port |

## Verification
The assertions assume that the neighbours follow the setup protocol. An acknowledge or refusal arrives only on an output that is carrying a probe still waiting for a reply, it lasts one cycle, and the two never arrive together. Data is sent only after the acknowledge has come back. The stimulus raises backward signals only after the matching probe has been seen on the output. It also sends data on unconnected inputs only in the cases where R8 expects that data to be dropped.

// File: rtl/noc_cs_pkg.sv
package noc_cs_pkg;

    localparam int NPORT = 5;
    localparam int PIW   = $clog2(NPORT);
    localparam int DW    = 8;
    localparam int CW    = 3;

    localparam int P_N = 0;
    localparam int P_E = 1;
    localparam int P_S = 2;
    localparam int P_W = 3;
    localparam int P_L = 4;

    localparam logic [NPORT-1:0] XDIR_MASK = NPORT'((1 << P_E) | (1 << P_W));

    typedef enum logic [1:0] {
        K_DATA  = 2'd0,
        K_PROBE = 2'd1,
        K_TEAR  = 2'd2,
        K_RSVD  = 2'd3
    } kind_e;

    typedef struct packed {
        logic          vld;
        kind_e         kind;
        logic [DW-1:0] pay;
    } flit_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SEEK,
        S_WAIT,
        S_CONN
    } ist_e;

    // Outputs that move a probe closer to (dx,dy) from (hx,hy).
    function automatic logic [NPORT-1:0] prod_dirs(
        input logic [CW-1:0] dx,
        input logic [CW-1:0] dy,
        input logic [CW-1:0] hx,
        input logic [CW-1:0] hy
    );
        logic [NPORT-1:0] m;
        m = '0;
        if (dx > hx) m[P_E] = 1'b1;
        if (dx < hx) m[P_W] = 1'b1;
        if (dy > hy) m[P_N] = 1'b1;
        if (dy < hy) m[P_S] = 1'b1;
        if (m == '0) m[P_L] = 1'b1;
        return m;
    endfunction

    function automatic logic [PIW-1:0] onehot_idx(input logic [NPORT-1:0] v);
        logic [PIW-1:0] r;
        r = '0;
        for (int k = 0; k < NPORT; k++) begin
            if (v[k]) r = PIW'(k);
        end
        return r;
    endfunction

endpackage

// File: rtl/noc_rr_arb.sv
module noc_rr_arb #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr;
    logic [IW-1:0] win;

    always_comb begin
        gnt = '0;
        win = '0;
        for (int k = 0; k < N; k++) begin
            int c;
            c = (int'(ptr) + k) % N;
            if (gnt == '0 && req[c]) begin
                gnt[c] = 1'b1;
                win    = IW'(c);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (|gnt) begin
            ptr <= (int'(win) == N - 1) ? '0 : win + 1'b1;
        end
    end

    p_gnt_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    p_gnt_in_req_r10: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);

endmodule

// File: rtl/noc_in_ctrl.sv
module noc_in_ctrl
    import noc_cs_pkg::*;
#(
    parameter int            IDX   = 0,
    parameter logic [CW-1:0] X_POS = '0,
    parameter logic [CW-1:0] Y_POS = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  flit_t            in_f,
    input  logic [NPORT-1:0] busy,
    input  logic             gnt,
    input  logic             dn_ack,
    input  logic             dn_nack,
    output logic [NPORT-1:0] req,
    output logic [PIW-1:0]   sel,
    output logic [DW-1:0]    hdr,
    output logic             fwd,
    output logic             rel,
    output logic             conn,
    output logic             up_ack,
    output logic             up_nack
);
    localparam logic [NPORT-1:0] OWN = NPORT'(1) << IDX;

    ist_e             st;
    logic [NPORT-1:0] tried;
    logic [NPORT-1:0] prod;
    logic [NPORT-1:0] cand;
    logic [NPORT-1:0] pick;

    always_comb begin
        prod = prod_dirs(hdr[2*CW-1:CW], hdr[CW-1:0], X_POS, Y_POS);
        cand = prod & ~tried & ~busy & ~OWN;
        pick = (|(cand & XDIR_MASK)) ? (cand & XDIR_MASK) : cand;
    end

    assign req  = (st == S_SEEK) ? pick : '0;
    assign conn = (st == S_CONN);
    assign fwd  = (st == S_CONN) && in_f.vld &&
                  (in_f.kind == K_DATA || in_f.kind == K_TEAR);
    assign rel  = ((st == S_WAIT) && dn_nack) ||
                  ((st == S_CONN) && in_f.vld && in_f.kind == K_TEAR);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            tried   <= '0;
            sel     <= '0;
            hdr     <= '0;
            up_ack  <= 1'b0;
            up_nack <= 1'b0;
        end else begin
            up_ack  <= 1'b0;
            up_nack <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (in_f.vld && in_f.kind == K_PROBE) begin
                        hdr   <= in_f.pay;
                        tried <= '0;
                        st    <= S_SEEK;
                    end
                end
                S_SEEK: begin
                    if (pick == '0) begin
                        up_nack <= 1'b1;
                        st      <= S_IDLE;
                    end else if (gnt) begin
                        sel <= onehot_idx(pick);
                        if (pick[P_L]) begin
                            up_ack <= 1'b1;
                            st     <= S_CONN;
                        end else begin
                            st <= S_WAIT;
                        end
                    end
                end
                S_WAIT: begin
                    if (dn_nack) begin
                        tried[sel] <= 1'b1;
                        st         <= S_SEEK;
                    end else if (dn_ack) begin
                        up_ack <= 1'b1;
                        st     <= S_CONN;
                    end
                end
                default: begin
                    if (in_f.vld && in_f.kind == K_TEAR) st <= S_IDLE;
                end
            endcase
        end
    end

    p_ack_nack_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(up_ack && up_nack));

    p_nack_leaves_idle_r4: assert property (@(posedge clk) disable iff (rst)
        up_nack |-> st == S_IDLE);

    p_gnt_needs_req_r10: assert property (@(posedge clk) disable iff (rst)
        gnt |-> (|req));

    p_ack_means_conn_r7: assert property (@(posedge clk) disable iff (rst)
        up_ack |-> st == S_CONN);

endmodule

// File: rtl/noc_out_ctrl.sv
module noc_out_ctrl
    import noc_cs_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPORT-1:0] gnt,
    input  logic [NPORT-1:0] rel,
    input  logic [NPORT-1:0] fwd,
    input  flit_t            in_f [NPORT],
    input  logic [DW-1:0]    hdr  [NPORT],
    output logic             busy,
    output logic [PIW-1:0]   owner,
    output flit_t            out_f
);
    logic [PIW-1:0] gidx;

    assign gidx = onehot_idx(gnt);

    // Owner register doubles as the crossbar select for this output.
    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            owner <= '0;
            out_f <= '0;
        end else if (|gnt) begin
            busy  <= 1'b1;
            owner <= gidx;
            out_f <= '{vld: 1'b1, kind: K_PROBE, pay: hdr[gidx]};
        end else begin
            if (busy && rel[owner]) busy <= 1'b0;
            if (busy && fwd[owner]) out_f <= in_f[owner];
            else                    out_f <= '0;
        end
    end

    p_no_regrant_r11: assert property (@(posedge clk) disable iff (rst)
        busy |-> !(|gnt));

    p_data_needs_owner_r8: assert property (@(posedge clk) disable iff (rst)
        (out_f.vld && out_f.kind == K_DATA) |-> $past(busy));

endmodule

// File: rtl/noc_cs_router.sv
module noc_cs_router
    import noc_cs_pkg::*;
#(
    parameter logic [CW-1:0] X_POS = 3'd3,
    parameter logic [CW-1:0] Y_POS = 3'd3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NPORT-1:0]    in_vld,
    input  logic [2*NPORT-1:0]  in_kind,
    input  logic [DW*NPORT-1:0] in_pay,
    output logic [NPORT-1:0]    out_vld,
    output logic [2*NPORT-1:0]  out_kind,
    output logic [DW*NPORT-1:0] out_pay,
    input  logic [NPORT-1:0]    bk_in_ack,
    input  logic [NPORT-1:0]    bk_in_nack,
    output logic [NPORT-1:0]    bk_out_ack,
    output logic [NPORT-1:0]    bk_out_nack
);
    flit_t            in_f   [NPORT];
    flit_t            out_f  [NPORT];
    logic [NPORT-1:0] req_v  [NPORT];
    logic [NPORT-1:0] arb_req[NPORT];
    logic [NPORT-1:0] arb_gnt[NPORT];
    logic [NPORT-1:0] rel_to [NPORT];
    logic [NPORT-1:0] fwd_to [NPORT];
    logic [PIW-1:0]   sel    [NPORT];
    logic [PIW-1:0]   owner  [NPORT];
    logic [DW-1:0]    hdr    [NPORT];
    logic [NPORT-1:0] busy;
    logic [NPORT-1:0] gnt_in;
    logic [NPORT-1:0] rel_v;
    logic [NPORT-1:0] fwd_v;
    logic [NPORT-1:0] conn_v;
    logic [NPORT-1:0] dn_ack;
    logic [NPORT-1:0] dn_nack;

    always_comb begin
        for (int j = 0; j < NPORT; j++)
            for (int i = 0; i < NPORT; i++)
                arb_req[j][i] = req_v[i][j] & ~busy[j];
    end

    always_comb begin
        for (int j = 0; j < NPORT; j++)
            for (int i = 0; i < NPORT; i++)
                rel_to[j][i] = rel_v[i] && (sel[i] == PIW'(j));
    end

    always_comb begin
        for (int j = 0; j < NPORT; j++)
            for (int i = 0; i < NPORT; i++)
                fwd_to[j][i] = fwd_v[i] && (sel[i] == PIW'(j));
    end

    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            gnt_in[i] = 1'b0;
            for (int j = 0; j < NPORT; j++)
                gnt_in[i] = gnt_in[i] | arb_gnt[j][i];
        end
    end

    // Backward replies are steered to the input that owns the output.
    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            dn_ack[i]  = 1'b0;
            dn_nack[i] = 1'b0;
            for (int j = 0; j < NPORT; j++) begin
                if (busy[j] && owner[j] == PIW'(i)) begin
                    dn_ack[i]  = dn_ack[i]  | bk_in_ack[j];
                    dn_nack[i] = dn_nack[i] | bk_in_nack[j];
                end
            end
        end
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        assign in_f[g] = '{vld:  in_vld[g],
                           kind: kind_e'(in_kind[2*g +: 2]),
                           pay:  in_pay[DW*g +: DW]};

        assign out_vld[g]           = out_f[g].vld;
        assign out_kind[2*g +: 2]   = out_f[g].kind;
        assign out_pay[DW*g +: DW]  = out_f[g].pay;

        noc_in_ctrl #(
            .IDX   (g),
            .X_POS (X_POS),
            .Y_POS (Y_POS)
        ) u_in (
            .clk     (clk),
            .rst     (rst),
            .in_f    (in_f[g]),
            .busy    (busy),
            .gnt     (gnt_in[g]),
            .dn_ack  (dn_ack[g]),
            .dn_nack (dn_nack[g]),
            .req     (req_v[g]),
            .sel     (sel[g]),
            .hdr     (hdr[g]),
            .fwd     (fwd_v[g]),
            .rel     (rel_v[g]),
            .conn    (conn_v[g]),
            .up_ack  (bk_out_ack[g]),
            .up_nack (bk_out_nack[g])
        );

        noc_rr_arb #(
            .N (NPORT)
        ) u_arb (
            .clk (clk),
            .rst (rst),
            .req (arb_req[g]),
            .gnt (arb_gnt[g])
        );

        noc_out_ctrl #(
            .IDX (g)
        ) u_out (
            .clk   (clk),
            .rst   (rst),
            .gnt   (arb_gnt[g]),
            .rel   (rel_to[g]),
            .fwd   (fwd_to[g]),
            .in_f  (in_f),
            .hdr   (hdr),
            .busy  (busy[g]),
            .owner (owner[g]),
            .out_f (out_f[g])
        );

        p_conn_owns_path_r7: assert property (@(posedge clk) disable iff (rst)
            conn_v[g] |-> (busy[sel[g]] && owner[sel[g]] == PIW'(g)));
    end

endmodule

// File: tb/noc_cs_router_tb_top.sv
module noc_cs_router_tb_top;
    import noc_cs_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NP         = 5;
    localparam int EV_ACK     = 4;
    localparam int EV_NACK    = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NP-1:0]    in_vld, out_vld, bk_in_ack, bk_in_nack, bk_out_ack, bk_out_nack;
    logic [2*NP-1:0]  in_kind, out_kind;
    logic [8*NP-1:0]  in_pay, out_pay;

    always #(CLK_PERIOD/2) clk = ~clk;

    noc_cs_router #(.X_POS(3'd3), .Y_POS(3'd3)) dut_i (
        .clk(clk), .rst(rst),
        .in_vld(in_vld), .in_kind(in_kind), .in_pay(in_pay),
        .out_vld(out_vld), .out_kind(out_kind), .out_pay(out_pay),
        .bk_in_ack(bk_in_ack), .bk_in_nack(bk_in_nack),
        .bk_out_ack(bk_out_ack), .bk_out_nack(bk_out_nack)
    );

    typedef struct {
        int         req;
        int         port;
        int         kind;
        logic [7:0] pay;
    } ev_t;

    ev_t expq[$];
    int  n_vec   = 0;
    int  n_bad   = 0;
    int  cur_req = 1;
    bit  done    = 1'b0;

    function automatic void push(int r, int p, int k, logic [7:0] b);
        ev_t e;
        e.req = r; e.port = p; e.kind = k; e.pay = b;
        expq.push_back(e);
    endfunction

    task automatic see(int p, int k, logic [7:0] b);
        ev_t e;
        n_vec++;
        if (expq.size() == 0) begin
            n_bad++;
            $display("FAIL R%0d: actual port %0d kind %0d byte %h, expected no output",
                     cur_req, p, k, b);
        end else begin
            e = expq.pop_front();
            if (e.port != p || e.kind != k || e.pay != b) begin
                n_bad++;
                $display("FAIL R%0d: actual port %0d kind %0d byte %h, expected port %0d kind %0d byte %h",
                         e.req, p, k, b, e.port, e.kind, e.pay);
            end
        end
    endtask

    // Monitor: forward outputs by port, then backward replies by port.
    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int p = 0; p < NP; p++)
                if (out_vld[p]) see(p, int'(out_kind[2*p +: 2]), out_pay[8*p +: 8]);
            for (int p = 0; p < NP; p++) begin
                if (bk_out_ack[p])  see(p, EV_ACK, 8'h00);
                if (bk_out_nack[p]) see(p, EV_NACK, 8'h00);
            end
        end
    end

    task automatic clear_in();
        in_vld = '0; in_kind = '0; in_pay = '0;
        bk_in_ack = '0; bk_in_nack = '0;
    endtask

    task automatic set_flit(int p, logic [1:0] k, logic [7:0] b);
        in_vld[p]         = 1'b1;
        in_kind[2*p +: 2] = k;
        in_pay[8*p +: 8]  = b;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        clear_in();
    endtask

    task automatic idle(int n);
        repeat (n) tick();
    endtask

    task automatic check_quiet(int r);
        @(negedge clk);
        n_vec++;
        if ((out_vld | bk_out_ack | bk_out_nack) != '0 || expq.size() != 0) begin
            n_bad++;
            $display("FAIL R%0d: actual outputs %b/%b/%b pending %0d, expected all quiet",
                     r, out_vld, bk_out_ack, bk_out_nack, expq.size());
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL R1: watchdog, actual run still busy, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        clear_in();
        // R1: quiet during and right after reset
        repeat (3) @(posedge clk);
        check_quiet(1);
        @(posedge clk); #1; rst = 1'b0;
        check_quiet(1);

        // R2: probe west->east, X resolved first, byte passed unchanged
        cur_req = 2;
        set_flit(3, K_PROBE, 8'h33); push(2, 1, 1, 8'h33); tick(); idle(3);
        // R7: downstream acknowledge relayed to west input
        cur_req = 7;
        bk_in_ack[1] = 1'b1; push(7, 3, EV_ACK, 8'h00); tick(); idle(2);
        // R8: data pipelined through one stage
        cur_req = 8;
        set_flit(3, K_DATA, 8'hA5); push(8, 1, 0, 8'hA5); tick();
        set_flit(3, K_DATA, 8'h5A); push(8, 1, 0, 8'h5A); tick(); idle(2);

        // R3: north input to (5,1), east reserved, so south is taken
        cur_req = 3;
        set_flit(0, K_PROBE, 8'h29); push(3, 2, 1, 8'h29); tick(); idle(3);
        // R8: data on a waiting input is dropped
        cur_req = 8;
        set_flit(0, K_DATA, 8'hEE); tick(); idle(2);
        check_quiet(8);

        // R4: local input to (5,2), east and south both reserved
        cur_req = 4;
        set_flit(4, K_PROBE, 8'h2A); push(4, 4, EV_NACK, 8'h00); tick(); idle(3);

        // R9: teardown on west forwarded, east released
        cur_req = 9;
        set_flit(3, K_TEAR, 8'h00); push(9, 1, 2, 8'h00); tick(); idle(2);
        // R5: refusal on south, retry takes freed east (also shows R9 release)
        cur_req = 5;
        bk_in_nack[2] = 1'b1; push(5, 1, 1, 8'h29); tick(); idle(3);
        bk_in_nack[1] = 1'b1; push(5, 0, EV_NACK, 8'h00); tick(); idle(3);
        check_quiet(5);

        // R6: probe for this node delivered locally with acknowledge
        cur_req = 6;
        set_flit(1, K_PROBE, 8'h1B); push(6, 4, 1, 8'h1B); push(6, 1, EV_ACK, 8'h00);
        tick(); idle(3);
        cur_req = 8;
        set_flit(1, K_DATA, 8'h77); push(8, 4, 0, 8'h77); tick();
        cur_req = 9;
        set_flit(1, K_TEAR, 8'h00); push(9, 4, 2, 8'h00); tick(); idle(2);

        // R8: data and ignored kind on idle inputs
        cur_req = 8;
        set_flit(2, K_DATA, 8'hC3); set_flit(3, K_RSVD, 8'h11); tick(); idle(2);
        check_quiet(8);

        // R10: east pointer sits at 1, west (3) wins over north (0)
        cur_req = 10;
        set_flit(0, K_PROBE, 8'h33); set_flit(3, K_PROBE, 8'h3B);
        push(10, 1, 1, 8'h3B);
        push(11, 0, EV_NACK, 8'h00); // R11: reserved east not granted to north
        tick(); idle(3);
        cur_req = 7;
        bk_in_ack[1] = 1'b1; push(7, 3, EV_ACK, 8'h00); tick(); idle(2);
        cur_req = 9;
        set_flit(3, K_TEAR, 8'h00); push(9, 1, 2, 8'h00); tick(); idle(2);
        // R10: pointer wrapped, north now wins
        cur_req = 10;
        set_flit(0, K_PROBE, 8'h33); set_flit(3, K_PROBE, 8'h3B);
        push(10, 1, 1, 8'h33); push(10, 3, EV_NACK, 8'h00); tick(); idle(3);
        cur_req = 5;
        bk_in_nack[1] = 1'b1; push(5, 0, EV_NACK, 8'h00); tick(); idle(3);

        // R2: both X and Y productive, X chosen; R5: retries Y then refuses
        cur_req = 2;
        set_flit(4, K_PROBE, 8'h2D); push(2, 1, 1, 8'h2D); tick(); idle(3);
        cur_req = 5;
        bk_in_nack[1] = 1'b1; push(5, 0, 1, 8'h2D); tick(); idle(3);
        bk_in_nack[0] = 1'b1; push(5, 4, EV_NACK, 8'h00); tick(); idle(3);
        check_quiet(5);

        idle(4);
        done = 1'b1;
        while (expq.size() != 0) begin
            ev_t e;
            e = expq.pop_front();
            n_vec++;
            n_bad++;
            $display("FAIL R%0d: actual nothing, expected port %0d kind %0d byte %h",
                     e.req, e.port, e.kind, e.pay);
        end
        summary();
        $finish;
    end

endmodule